// File: doc/BRIEF.md
# GPIO Port with Alternate-Function Override Muxing

This block is one general-purpose I/O port of `W` pins (8 by default). Each pin has a direction bit and an output-value bit, and a small register bus writes and reads them. The port drives a pad model made of an output value, an output enable and a pull-up enable. It returns two things from the pad: a pin value, which passes through a two-stage synchronizer and is read over the bus, and a raw digital input tap for alternate-function peripherals, which bypasses the synchronizer.

Peripherals that share a pin can take it over through four enable/value override pairs per pin. One pair each covers the pull-up, the output driver enable, the driven value and the digital input enable. A pin whose override enables are all low stays under register control. A port-wide pull-up-disable input and a deep-sleep input act on every pin. The deep-sleep input turns the digital input off unless an override keeps it on. A disabled input feeds 0 to both the raw tap and the synchronizer, so a floating pad cannot toggle either one.

Bus map (`regAddr`): 0 = synchronized pin value (read only), 1 = direction bits, 2 = output-value bits, 3 = unused. The bus has no read strobe: `rdData` always shows the location selected by `regAddr`.

Top module: `gpio_port_ovr`

## Requirements
- R1: An active-low `rstN` clears the direction and output-value bits asynchronously. While it is low, `padOe` and `padOut` are 0. `padPullup` is also 0 on every pin that has no pull-up override.
- R2: A write (`regWr`=1) at address 1 loads the direction bits, and a write at address 2 loads the output-value bits, both at the next rising edge. Reading address 1 or 2 returns those bits. Writes to addresses 0 and 3 change nothing, and reading address 3 returns 0.
- R3: A pin with its pull-up override enable low has its pull-up on only when its direction bit is 0, its output-value bit is 1 and `pullupDisable` is 0.
- R4: A pin with its pull-up override enable high has `padPullup` equal to its pull-up override value, whatever the direction bit, output-value bit and `pullupDisable` are.
- R5: `padOe` equals the direction override value when the direction override enable is high. Otherwise it equals the direction bit.
- R6: When `padOe` is 1, `padOut` is the value override when the value override enable is high, and the output-value bit otherwise. When `padOe` is 0, `padOut` is 0.
- R7: The digital input enable equals the input-enable override value when that override enable is high. Otherwise it is 1 when `sleepGate` is 0 and 0 when `sleepGate` is 1.
- R8: `rawIn` equals `padIn` in the same cycle when the digital input is enabled, and is 0 when it is disabled. It passes through no register.
- R9: A value on `rawIn` before rising edge k appears at bus address 0 after edge k+1 and not earlier. The read value is therefore 0 two edges after the input is disabled.
- R10: Each pin's overrides act on that pin alone. `pullupDisable` and `sleepGate` act on every pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| wrData | input | W | Write data |
| rdData | output | W | Read data for the selected address |
| pullupDisable | input | 1 | Port-wide pull-up disable |
| sleepGate | input | 1 | Deep-sleep input gating request |
| puOvrEn | input | W | Pull-up override enable per pin |
| puOvrVal | input | W | Pull-up override value per pin |
| dirOvrEn | input | W | Direction override enable per pin |
| dirOvrVal | input | W | Direction override value per pin |
| valOvrEn | input | W | Output-value override enable per pin |
| valOvrVal | input | W | Output-value override value per pin |
| inEnOvrEn | input | W | Input-enable override enable per pin |
| inEnOvrVal | input | W | Input-enable override value per pin |
| padIn | input | W | Level seen at each pad |
| padOut | output | W | Value driven to each pad |
| padOe | output | W | Output driver enable per pad |
| padPullup | output | W | Pull-up enable per pad |
| rawIn | output | W | Unsynchronized gated input for peripherals |

## Verification
Two functions can act in the same cycle: a peripheral's override and the register settings it pre-empts. A register write can also land while an override holds the same pin. The bench sets contradictory register bits, then walks all sixteen override-enable combinations, on a subset of pins and both with and without sleep gating. It compares every pad output against a model built from the requirements. Pins outside the subset must keep their register behaviour. A second overlap is between the sleep gate and the synchronizer. The bench changes the pad and the gate on successive cycles and judges the read value at exactly the edges the two-stage latency predicts.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int GPIO_ADDR_W = 2;
  localparam logic [GPIO_ADDR_W-1:0] ADDR_PIN = 2'd0;
  localparam logic [GPIO_ADDR_W-1:0] ADDR_DIR = 2'd1;
  localparam logic [GPIO_ADDR_W-1:0] ADDR_VAL = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic wrDir;
    logic wrVal;
    logic rdPin;
    logic rdDir;
    logic rdVal;
  } gpioStrb_t;
endpackage

// File: rtl/gpio_ovr_ctrl.sv
module gpio_ovr_ctrl
  import gpio_ovr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWr,
  input  logic [GPIO_ADDR_W-1:0] regAddr,
  output gpioStrb_t              strb
);

  always_comb begin
    strb       = '0;
    strb.rdPin = (regAddr == ADDR_PIN);
    strb.rdDir = (regAddr == ADDR_DIR);
    strb.rdVal = (regAddr == ADDR_VAL);
    strb.wrDir = regWr && (regAddr == ADDR_DIR);
    strb.wrVal = regWr && (regAddr == ADDR_VAL);
  end

  // R2: at most one register loads per cycle
  p_one_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrDir, strb.wrVal}));

endmodule

// File: rtl/gpio_ovr_dp.sv
module gpio_ovr_dp
  import gpio_ovr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  gpioStrb_t     strb,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  rdData,
  input  logic          pullupDisable,
  input  logic          sleepGate,
  input  logic [W-1:0]  puOvrEn,
  input  logic [W-1:0]  puOvrVal,
  input  logic [W-1:0]  dirOvrEn,
  input  logic [W-1:0]  dirOvrVal,
  input  logic [W-1:0]  valOvrEn,
  input  logic [W-1:0]  valOvrVal,
  input  logic [W-1:0]  inEnOvrEn,
  input  logic [W-1:0]  inEnOvrVal,
  input  logic [W-1:0]  padIn,
  output logic [W-1:0]  padOut,
  output logic [W-1:0]  padOe,
  output logic [W-1:0]  padPullup,
  output logic [W-1:0]  rawIn
);

  logic [W-1:0] dirQ, valQ;
  logic [W-1:0] syncA, syncB;
  logic [W-1:0] inEn;
  logic [W-1:0] outSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
      valQ <= '0;
    end else begin
      if (strb.wrDir) dirQ <= wrData;
      if (strb.wrVal) valQ <= wrData;
    end
  end

  // per-pin override muxes
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign padPullup[i] = puOvrEn[i]  ? puOvrVal[i]
                                      : (~dirQ[i] & valQ[i] & ~pullupDisable);
    assign padOe[i]     = dirOvrEn[i] ? dirOvrVal[i] : dirQ[i];
    assign outSel[i]    = valOvrEn[i] ? valOvrVal[i] : valQ[i];
    assign padOut[i]    = padOe[i] & outSel[i];
    assign inEn[i]      = inEnOvrEn[i] ? inEnOvrVal[i] : ~sleepGate;
    assign rawIn[i]     = padIn[i] & inEn[i];
  end

  // two-stage pin synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
    end
  end

  assign rdData = ({W{strb.rdPin}} & syncB)
                | ({W{strb.rdDir}} & dirQ)
                | ({W{strb.rdVal}} & valQ);

  // edges since reset, saturating at 2, for the latency check
  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               warmCnt <= '0;
    else if (warmCnt != 2'd2) warmCnt <= warmCnt + 2'd1;
  end

  p_wr_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> dirQ == $past(wrData));
  p_wr_val_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrVal |=> valQ == $past(wrData));
  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(dirQ));
  p_sync_lat_r9: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd2) |-> syncB == $past(rawIn, 2));
  p_sleep_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sleepGate && inEnOvrEn == '0) |=> syncA == '0);

endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_ovr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWr,
  input  logic [1:0]   regAddr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  input  logic         pullupDisable,
  input  logic         sleepGate,
  input  logic [W-1:0] puOvrEn,
  input  logic [W-1:0] puOvrVal,
  input  logic [W-1:0] dirOvrEn,
  input  logic [W-1:0] dirOvrVal,
  input  logic [W-1:0] valOvrEn,
  input  logic [W-1:0] valOvrVal,
  input  logic [W-1:0] inEnOvrEn,
  input  logic [W-1:0] inEnOvrVal,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] padOut,
  output logic [W-1:0] padOe,
  output logic [W-1:0] padPullup,
  output logic [W-1:0] rawIn
);

  gpioStrb_t strb;

  gpio_ovr_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regAddr (regAddr),
    .strb    (strb)
  );

  gpio_ovr_dp #(.W(W)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .wrData        (wrData),
    .rdData        (rdData),
    .pullupDisable (pullupDisable),
    .sleepGate     (sleepGate),
    .puOvrEn       (puOvrEn),
    .puOvrVal      (puOvrVal),
    .dirOvrEn      (dirOvrEn),
    .dirOvrVal     (dirOvrVal),
    .valOvrEn      (valOvrEn),
    .valOvrVal     (valOvrVal),
    .inEnOvrEn     (inEnOvrEn),
    .inEnOvrVal    (inEnOvrVal),
    .padIn         (padIn),
    .padOut        (padOut),
    .padOe         (padOe),
    .padPullup     (padPullup),
    .rawIn         (rawIn)
  );

endmodule

// File: tb/test_gpio_port_ovr.sv
module test_gpio_port_ovr;
  localparam int W = 8;

  logic clk = 0;
  logic rstN = 0;
  logic regWr = 0;
  logic [1:0] regAddr = 0;
  logic [W-1:0] wrData = 0;
  logic [W-1:0] rdData;
  logic pullupDisable = 0, sleepGate = 0;
  logic [W-1:0] puOvrEn = 0, puOvrVal = 0, dirOvrEn = 0, dirOvrVal = 0;
  logic [W-1:0] valOvrEn = 0, valOvrVal = 0, inEnOvrEn = 0, inEnOvrVal = 0;
  logic [W-1:0] padIn = 0;
  logic [W-1:0] padOut, padOe, padPullup, rawIn;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_port_ovr #(.W(W)) i_gpio_port_ovr (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData),
    .pullupDisable(pullupDisable), .sleepGate(sleepGate),
    .puOvrEn(puOvrEn), .puOvrVal(puOvrVal),
    .dirOvrEn(dirOvrEn), .dirOvrVal(dirOvrVal),
    .valOvrEn(valOvrEn), .valOvrVal(valOvrVal),
    .inEnOvrEn(inEnOvrEn), .inEnOvrVal(inEnOvrVal),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .padPullup(padPullup), .rawIn(rawIn)
  );

  // {dir,val,pud,sleep, en[pu,dd,pv,ie], ov[pu,dd,pv,ie], pad, exp[pull,oe,out,raw]}
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    {4'b0100, 4'b0000, 4'b0000, 1'b1, 4'b1001},
    {4'b0110, 4'b0000, 4'b0000, 1'b0, 4'b0000},
    {4'b1100, 4'b0000, 4'b0000, 1'b1, 4'b0111},
    {4'b1000, 4'b0000, 4'b0000, 1'b0, 4'b0100},
    {4'b1010, 4'b1000, 4'b1000, 1'b0, 4'b1100},
    {4'b0100, 4'b1000, 4'b0000, 1'b1, 4'b0001},
    {4'b0100, 4'b0100, 4'b0100, 1'b1, 4'b1111},
    {4'b1100, 4'b0100, 4'b0000, 1'b1, 4'b0001},
    {4'b1100, 4'b0010, 4'b0000, 1'b0, 4'b0100},
    {4'b0000, 4'b0010, 4'b0010, 1'b1, 4'b0001},
    {4'b0001, 4'b0000, 4'b0000, 1'b1, 4'b0000},
    {4'b0001, 4'b0001, 4'b0001, 1'b1, 4'b0001},
    {4'b0000, 4'b0001, 4'b0000, 1'b1, 4'b0000},
    {4'b0011, 4'b1111, 4'b1111, 1'b1, 4'b1111}
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; regWr = 1;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic busRead(input logic [1:0] a, input string tag, input logic [W-1:0] exp);
    regAddr = a;
    #1 check(tag, rdData, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] expPu, expOe, expOut, expRaw;
    // R1: outputs quiet during reset
    repeat (2) @(negedge clk);
    check("R1 oe in reset", padOe, '0);
    check("R1 pullup in reset", padPullup, '0);
    rstN = 1;
    @(negedge clk);
    busRead(2'd1, "R1 dir after reset", '0);
    busRead(2'd2, "R1 val after reset", '0);

    // R2: bus map
    busWrite(2'd1, 8'hC3);
    busRead(2'd1, "R2 dir readback", 8'hC3);
    busWrite(2'd2, 8'h5A);
    busRead(2'd2, "R2 val readback", 8'h5A);
    busWrite(2'd3, 8'hFF);
    busWrite(2'd0, 8'hFF);
    busRead(2'd1, "R2 dir after ignored writes", 8'hC3);
    busRead(2'd2, "R2 val after ignored writes", 8'h5A);
    busRead(2'd3, "R2 unused reads zero", '0);

    // R1: async reset mid-run clears driven state
    @(negedge clk);
    rstN = 0;
    #1 check("R1 oe on async reset", padOe, '0);
    check("R1 out on async reset", padOut, '0);
    @(negedge clk);
    rstN = 1;

    // vector table, broadcast to all pins
    for (int k = 0; k < NV; k++) begin
      busWrite(2'd1, {W{VEC[k][16]}});
      busWrite(2'd2, {W{VEC[k][15]}});
      pullupDisable = VEC[k][14];
      sleepGate  = VEC[k][13];
      puOvrEn    = {W{VEC[k][12]}}; dirOvrEn  = {W{VEC[k][11]}};
      valOvrEn   = {W{VEC[k][10]}}; inEnOvrEn = {W{VEC[k][9]}};
      puOvrVal   = {W{VEC[k][8]}};  dirOvrVal = {W{VEC[k][7]}};
      valOvrVal  = {W{VEC[k][6]}};  inEnOvrVal = {W{VEC[k][5]}};
      padIn      = {W{VEC[k][4]}};
      #1;
      check($sformatf("R3/R4 pullup vec %0d", k), padPullup, {W{VEC[k][3]}});
      check($sformatf("R5 oe vec %0d", k), padOe, {W{VEC[k][2]}});
      check($sformatf("R6 out vec %0d", k), padOut, {W{VEC[k][1]}});
      check($sformatf("R7/R8 raw vec %0d", k), rawIn, {W{VEC[k][0]}});
    end

    // R10: every override combination on a pin subset, both sleep states
    busWrite(2'd1, 8'h33);
    busWrite(2'd2, 8'h55);
    pullupDisable = 0;
    puOvrVal = 8'hF0; dirOvrVal = 8'hCC; valOvrVal = 8'hAA; inEnOvrVal = 8'h0F;
    padIn = 8'hE7;
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 16; e++) begin
        @(negedge clk);
        sleepGate = s[0];
        puOvrEn   = e[3] ? 8'h5A : 8'h00;
        dirOvrEn  = e[2] ? 8'h5A : 8'h00;
        valOvrEn  = e[1] ? 8'h5A : 8'h00;
        inEnOvrEn = e[0] ? 8'h5A : 8'h00;
        for (int b = 0; b < W; b++) begin
          logic d, v, ie;
          d  = 8'h33 >> b; v = 8'h55 >> b;
          expPu[b]  = puOvrEn[b]  ? puOvrVal[b]  : (!d && v);
          expOe[b]  = dirOvrEn[b] ? dirOvrVal[b] : d;
          expOut[b] = expOe[b] && (valOvrEn[b] ? valOvrVal[b] : v);
          ie        = inEnOvrEn[b] ? inEnOvrVal[b] : !s[0];
          expRaw[b] = ie && padIn[b];
        end
        #1;
        check("R10 pullup", padPullup, expPu);
        check("R10 oe", padOe, expOe);
        check("R10 out", padOut, expOut);
        check("R10 raw", rawIn, expRaw);
      end
    end

    // R9: synchronizer latency
    @(negedge clk);
    puOvrEn = 0; dirOvrEn = 0; valOvrEn = 0; inEnOvrEn = 0;
    sleepGate = 0; padIn = 8'h00; regAddr = 2'd0;
    repeat (3) @(negedge clk);
    padIn = 8'h96;
    #1 check("R8 raw same cycle", rawIn, 8'h96);
    check("R9 before edge", rdData, 8'h00);
    @(negedge clk);
    check("R9 after one edge", rdData, 8'h00);
    @(negedge clk);
    check("R9 after two edges", rdData, 8'h96);
    sleepGate = 1;
    #1 check("R7 sleep gates raw", rawIn, 8'h00);
    @(negedge clk);
    check("R9 gated after one edge", rdData, 8'h96);
    @(negedge clk);
    check("R9 gated after two edges", rdData, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule